// File: doc/BRIEF.md
# Conditional Skip Flag Unit

This block decides whether a small 4-bit processor discards its next instruction. A 4-bit condition select, driven by the decoder for the instruction now finishing, picks one of sixteen one-bit sources. The picked bit is stored in a skip flag on the edge where the instruction-complete strobe is high. While the flag is set, the fetched opcode byte is swapped for the no-op byte 0x00 before it reaches the rest of the core. Skipping an instruction therefore costs exactly the cycles that instruction would have taken. The processor needs no separate branch path.

The condition signals come in as ready bits from elsewhere in the core: carry, ALU carry-out, comparator results, the tested bit, the masked I/K input nibble, two flags and a seconds input. One select code feeds the skip flag back into itself. When a page-prepare instruction is skipped, it uses this code to pass the skip on to the jump that follows it. This lets a conditional jump reach any page.

Top module: `skip_unit`

## Requirements
- R1: While `rst_n` is low, `skip_flag` is 0 and is cleared on the next rising clock edge; after reset, `opcode_out` equals `opcode_in`.
- R2: `skip_flag` changes only on a rising edge where `instr_done` is 1; with `instr_done` at 0 it holds its value whatever the select and condition inputs do.
- R3: Select code 0 loads 0 (never skip) and select code 1 loads 1 (always skip), regardless of the condition inputs.
- R4: Select code 4 loads 1 when `carry` is 0; select code 5 loads 1 when `alu_cout` is 0; each loads 0 otherwise.
- R5: Select codes 3, 6, 8 and 9 load `bl_eq_e`, `a_eq_m`, `bl_is_15` and `bl_is_0` respectively, unchanged.
- R6: Select code 7 loads 1 when `bit_val` is 0 and 0 when it is 1.
- R7: Select code 10 loads 1 exactly when all four bits of `ik_masked` are 0.
- R8: Select codes 2, 12 and 13 load `sec_in`, `flag_f1` and `flag_f2` respectively, unchanged.
- R9: Select code 11 reloads the current `skip_flag`, so a set flag stays set and a clear flag stays clear.
- R10: Select codes 14 and 15 load 0, whatever the condition inputs are.
- R11: While `skip_flag` is 1, `opcode_out` is 0x00 in the same cycle; while it is 0, `opcode_out` equals `opcode_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_done | input | 1 | Instruction-complete strobe; enables the flag update |
| cond_sel | input | 4 | Condition select code |
| carry | input | 1 | Carry register value |
| alu_cout | input | 1 | Carry out of the ALU for the current operation |
| a_eq_m | input | 1 | Accumulator equals RAM word |
| bl_eq_e | input | 1 | BL register equals E register |
| bl_is_15 | input | 1 | BL register holds 15 |
| bl_is_0 | input | 1 | BL register holds 0 |
| bit_val | input | 1 | Value of the bit under test |
| ik_masked | input | 4 | I/K input nibble after masking |
| flag_f1 | input | 1 | Flag F1 |
| flag_f2 | input | 1 | Flag F2 |
| sec_in | input | 1 | External seconds-related input |
| opcode_in | input | 8 | Fetched opcode byte |
| opcode_out | output | 8 | Effective opcode, forced to 0x00 while skipping |
| skip_flag | output | 1 | Registered skip flag |

## Verification
In a single cycle the unit can both mask the current opcode, using the flag already stored, and load a new flag value for the next instruction. A wrong design could let the new value leak into the current cycle, or let the masking depend on the select code. The bench sets the flag and then presents a nonzero opcode together with an `instr_done` strobe carrying either the never-skip code or the pass-through code. It requires 0x00 at the output in that cycle, and in the following cycle it requires either the unchanged opcode or 0x00 again.

// File: rtl/skip_pkg.sv
package skip_pkg;

  localparam int SEL_W = 4;
  localparam int N_SEL = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_NEVER     = 4'd0,
    SEL_ALWAYS    = 4'd1,
    SEL_SEC       = 4'd2,
    SEL_BL_EQ_E   = 4'd3,
    SEL_CARRY_CLR = 4'd4,
    SEL_NO_COUT   = 4'd5,
    SEL_A_EQ_M    = 4'd6,
    SEL_BIT_ZERO  = 4'd7,
    SEL_BL_15     = 4'd8,
    SEL_BL_0      = 4'd9,
    SEL_IK_ZERO   = 4'd10,
    SEL_HOLD      = 4'd11,
    SEL_F1        = 4'd12,
    SEL_F2        = 4'd13
  } cond_sel_e;

  // True when no bit of a nibble is set.
  function automatic logic nibble_clear(input logic [3:0] v);
    return (v == 4'h0);
  endfunction

  // Pick the effective opcode: substitute the no-op byte while skipping.
  function automatic logic [7:0] masked_op(input logic skip, input logic [7:0] op,
                                           input logic [7:0] nop);
    return skip ? nop : op;
  endfunction

endpackage

// File: rtl/skip_cond_mux.sv
module skip_cond_mux
  import skip_pkg::*;
#(
  parameter int SW   = SEL_W,
  parameter int IK_W = 4
) (
  input  logic [SW-1:0]   sel,
  input  logic            carry,
  input  logic            alu_cout,
  input  logic            a_eq_m,
  input  logic            bl_eq_e,
  input  logic            bl_is_15,
  input  logic            bl_is_0,
  input  logic            bit_val,
  input  logic [IK_W-1:0] ik_masked,
  input  logic            flag_f1,
  input  logic            flag_f2,
  input  logic            sec_in,
  input  logic            cur_flag,
  output logic            cond_bit
);

  localparam int NSRC = 1 << SW;

  logic [NSRC-1:0] src;
  logic            ik_none;

  assign ik_none = ~|ik_masked;

  always_comb begin
    src                     = '0;
    src[SEL_ALWAYS]         = 1'b1;
    src[SEL_SEC]            = sec_in;
    src[SEL_BL_EQ_E]        = bl_eq_e;
    src[SEL_CARRY_CLR]      = ~carry;
    src[SEL_NO_COUT]        = ~alu_cout;
    src[SEL_A_EQ_M]         = a_eq_m;
    src[SEL_BIT_ZERO]       = ~bit_val;
    src[SEL_BL_15]          = bl_is_15;
    src[SEL_BL_0]           = bl_is_0;
    src[SEL_IK_ZERO]        = ik_none;
    src[SEL_HOLD]           = cur_flag;
    src[SEL_F1]             = flag_f1;
    src[SEL_F2]             = flag_f2;
  end

  assign cond_bit = src[sel];

endmodule

// File: rtl/skip_flag_reg.sv
module skip_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= 1'b0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/skip_op_mask.sv
module skip_op_mask
  import skip_pkg::*;
#(
  parameter int           OP_W     = 8,
  parameter logic [7:0]   NOP_CODE = 8'h00
) (
  input  logic            skip,
  input  logic [OP_W-1:0] op_in,
  output logic [OP_W-1:0] op_out
);

  generate
    if (OP_W == 8) begin : g_byte
      assign op_out = masked_op(skip, op_in, NOP_CODE);
    end else begin : g_wide
      assign op_out = skip ? OP_W'(NOP_CODE) : op_in;
    end
  endgenerate

endmodule

// File: rtl/skip_unit.sv
module skip_unit
  import skip_pkg::*;
#(
  parameter int         OP_W     = 8,
  parameter int         IK_W     = 4,
  parameter logic [7:0] NOP_CODE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic              carry,
  input  logic              alu_cout,
  input  logic              a_eq_m,
  input  logic              bl_eq_e,
  input  logic              bl_is_15,
  input  logic              bl_is_0,
  input  logic              bit_val,
  input  logic [IK_W-1:0]   ik_masked,
  input  logic              flag_f1,
  input  logic              flag_f2,
  input  logic              sec_in,
  input  logic [OP_W-1:0]   opcode_in,
  output logic [OP_W-1:0]   opcode_out,
  output logic              skip_flag
);

  // Selected condition, brought out by name for the checker.
  logic cond_bit;

  skip_cond_mux #(.SW(SEL_W), .IK_W(IK_W)) u_mux (
    .sel       (cond_sel),
    .carry     (carry),
    .alu_cout  (alu_cout),
    .a_eq_m    (a_eq_m),
    .bl_eq_e   (bl_eq_e),
    .bl_is_15  (bl_is_15),
    .bl_is_0   (bl_is_0),
    .bit_val   (bit_val),
    .ik_masked (ik_masked),
    .flag_f1   (flag_f1),
    .flag_f2   (flag_f2),
    .sec_in    (sec_in),
    .cur_flag  (skip_flag),
    .cond_bit  (cond_bit)
  );

  skip_flag_reg u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (instr_done),
    .d     (cond_bit),
    .q     (skip_flag)
  );

  skip_op_mask #(.OP_W(OP_W), .NOP_CODE(NOP_CODE)) u_mask (
    .skip   (skip_flag),
    .op_in  (opcode_in),
    .op_out (opcode_out)
  );

endmodule

// File: rtl/skip_unit_chk.sv
module skip_unit_chk #(
  parameter int OP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_done,
  input logic [3:0]      cond_sel,
  input logic [OP_W-1:0] opcode_in,
  input logic [OP_W-1:0] opcode_out,
  input logic            skip_flag,
  input logic            cond_bit
);

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> !skip_flag); // R1

  AST_HOLD_WITHOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |=> $stable(skip_flag)); // R2

  AST_LOADS_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> (skip_flag == $past(cond_bit))); // R2

  AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && cond_sel == 4'd0) |=> !skip_flag); // R3

  AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && cond_sel == 4'd1) |=> skip_flag); // R3

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && cond_sel == 4'd11) |=> $stable(skip_flag)); // R9

  AST_UNUSED_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && cond_sel >= 4'd14) |=> !skip_flag); // R10

  AST_MASK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    skip_flag |-> (opcode_out == '0)); // R11

  AST_PASS_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_flag |-> (opcode_out == opcode_in)); // R11

endmodule

bind skip_unit skip_unit_chk #(.OP_W(OP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr_done (instr_done),
  .cond_sel   (cond_sel),
  .opcode_in  (opcode_in),
  .opcode_out (opcode_out),
  .skip_flag  (skip_flag),
  .cond_bit   (cond_bit)
);

// File: tb/skip_unit_tb.sv
module skip_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       instr_done;
  logic [3:0] cond_sel;
  logic       carry, alu_cout, a_eq_m, bl_eq_e, bl_is_15, bl_is_0, bit_val;
  logic [3:0] ik_masked;
  logic       flag_f1, flag_f2, sec_in;
  logic [7:0] opcode_in;
  logic [7:0] opcode_out;
  logic       skip_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  skip_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .cond_sel(cond_sel),
    .carry(carry), .alu_cout(alu_cout), .a_eq_m(a_eq_m), .bl_eq_e(bl_eq_e),
    .bl_is_15(bl_is_15), .bl_is_0(bl_is_0), .bit_val(bit_val),
    .ik_masked(ik_masked), .flag_f1(flag_f1), .flag_f2(flag_f2),
    .sec_in(sec_in), .opcode_in(opcode_in), .opcode_out(opcode_out),
    .skip_flag(skip_flag)
  );

  // Vector: {req[4:0], sel[3:0], sources[13:0], expected flag}
  // sources bit: 0 carry, 1 alu_cout, 2 a_eq_m, 3 bl_eq_e, 4 bl_is_15,
  //              5 bl_is_0, 6 bit_val, 10:7 ik_masked, 11 f1, 12 f2, 13 sec
  localparam int NV = 33;
  localparam logic [23:0] VEC [NV] = '{
    {5'd3,  4'd0,  14'h3FFF, 1'b0},  // R3 never
    {5'd3,  4'd1,  14'h0000, 1'b1},  // R3 always
    {5'd4,  4'd4,  14'h3FFE, 1'b1},  // R4 carry clear
    {5'd4,  4'd4,  14'h3FFF, 1'b0},  // R4
    {5'd4,  4'd5,  14'h3FFD, 1'b1},  // R4 no carry-out
    {5'd4,  4'd5,  14'h0002, 1'b0},  // R4
    {5'd5,  4'd3,  14'h0008, 1'b1},  // R5 BL==E
    {5'd5,  4'd3,  14'h3FF7, 1'b0},  // R5
    {5'd5,  4'd6,  14'h0004, 1'b1},  // R5 A==M
    {5'd5,  4'd6,  14'h3FFB, 1'b0},  // R5
    {5'd5,  4'd8,  14'h0010, 1'b1},  // R5 BL==15
    {5'd5,  4'd8,  14'h3FEF, 1'b0},  // R5
    {5'd5,  4'd9,  14'h0020, 1'b1},  // R5 BL==0
    {5'd5,  4'd9,  14'h3FDF, 1'b0},  // R5
    {5'd6,  4'd7,  14'h3FBF, 1'b1},  // R6 bit zero
    {5'd6,  4'd7,  14'h0040, 1'b0},  // R6
    {5'd7,  4'd10, 14'h387F, 1'b1},  // R7 ik all zero
    {5'd7,  4'd10, 14'h0080, 1'b0},  // R7 ik lsb set
    {5'd7,  4'd10, 14'h0400, 1'b0},  // R7 ik msb set
    {5'd7,  4'd10, 14'h0000, 1'b1},  // R7
    {5'd8,  4'd2,  14'h2000, 1'b1},  // R8 sec
    {5'd8,  4'd2,  14'h1FFF, 1'b0},  // R8
    {5'd8,  4'd12, 14'h0800, 1'b1},  // R8 f1
    {5'd8,  4'd12, 14'h37FF, 1'b0},  // R8
    {5'd8,  4'd13, 14'h1000, 1'b1},  // R8 f2
    {5'd8,  4'd13, 14'h2FFF, 1'b0},  // R8
    {5'd3,  4'd1,  14'h0000, 1'b1},  // R3 set before unused
    {5'd10, 4'd14, 14'h3FFF, 1'b0},  // R10
    {5'd3,  4'd1,  14'h0000, 1'b1},  // R3
    {5'd10, 4'd15, 14'h3FFF, 1'b0},  // R10
    {5'd5,  4'd9,  14'h0020, 1'b1},  // R5
    {5'd3,  4'd0,  14'h0000, 1'b0},  // R3
    {5'd6,  4'd7,  14'h0000, 1'b1}   // R6
  };

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: skip_flag actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: opcode_out actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive_srcs(input logic [13:0] s);
    carry = s[0]; alu_cout = s[1]; a_eq_m = s[2]; bl_eq_e = s[3];
    bl_is_15 = s[4]; bl_is_0 = s[5]; bit_val = s[6]; ik_masked = s[10:7];
    flag_f1 = s[11]; flag_f2 = s[12]; sec_in = s[13];
  endtask

  // One completed instruction: strobe for one edge, return after it.
  task automatic complete(input logic [3:0] sel);
    @(negedge clk);
    cond_sel = sel; instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; instr_done = 1'b0; cond_sel = 4'd0; opcode_in = 8'h5A;
    drive_srcs(14'h0000);
    repeat (3) @(negedge clk);
    check1("R1", skip_flag, 1'b0);
    check8("R1", opcode_out, 8'h5A);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] op;
      op = 8'h80 + 8'(i);
      @(negedge clk);
      drive_srcs(VEC[i][14:1]);
      opcode_in = op;
      complete(VEC[i][18:15]);
      check1($sformatf("R%0d vec %0d", VEC[i][23:19], i), skip_flag, VEC[i][0]);
      check8("R11", opcode_out, VEC[i][0] ? 8'h00 : op);
    end

    // R2: no strobe, flag holds while select and conditions move
    complete(4'd1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cond_sel = 4'(k * 4); drive_srcs(14'h0000);
      @(negedge clk);
      check1("R2 hold set", skip_flag, 1'b1);
    end
    complete(4'd0);
    @(negedge clk); cond_sel = 4'd1;
    repeat (2) @(negedge clk);
    check1("R2 hold clear", skip_flag, 1'b0);

    // R9: pass-through keeps set and keeps clear
    complete(4'd1);
    drive_srcs(14'h0000);
    complete(4'd11);
    check1("R9 keep set", skip_flag, 1'b1);
    complete(4'd11);
    check1("R9 keep set again", skip_flag, 1'b1);
    complete(4'd0);
    drive_srcs(14'h3FFF);
    complete(4'd11);
    check1("R9 keep clear", skip_flag, 1'b0);

    // Same cycle: masked opcode while a new flag value loads
    complete(4'd1);
    @(negedge clk);
    opcode_in = 8'hC3; cond_sel = 4'd0; instr_done = 1'b1;
    #1 check8("R11 masked during load", opcode_out, 8'h00);
    @(negedge clk);
    instr_done = 1'b0;
    check8("R11 released", opcode_out, 8'hC3);
    complete(4'd1);
    @(negedge clk);
    opcode_in = 8'h3C; cond_sel = 4'd11; instr_done = 1'b1;
    #1 check8("R11 masked during hold", opcode_out, 8'h00);
    @(negedge clk);
    instr_done = 1'b0;
    check8("R9 skip chained", opcode_out, 8'h00);

    // R1: reset in mid-run clears a set flag
    complete(4'd1);
    @(negedge clk); rst_n = 1'b0; opcode_in = 8'hE7;
    @(negedge clk);
    check1("R1 mid reset", skip_flag, 1'b0);
    check8("R1 mid reset", opcode_out, 8'hE7);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule